// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register file of a small processor core. It holds sixteen 32-bit registers that instruction logic reads and writes through numbered addresses. Some of those registers have extra copies, and which copy is visible depends on the processor operating mode. When the core changes mode, the register file swaps the copies that belong to the old mode out of the visible set and brings in the copies that belong to the new mode. From then on, the read and write ports see the new mode's registers without any change to their addressing.

The operating mode enters as a 5-bit value with a one-cycle change strobe. Only the low four bits choose the bank. Six banks exist: main, fast-interrupt, interrupt, supervisor, abort and undefined. Registers 13 and 14 have a private pair in every bank. Registers 8 to 12 have exactly two copies: one for the fast-interrupt bank and one shared by every other bank. Every bank except main also owns one saved-status word, which is read and written through a dedicated port that always targets the current bank.

The swap itself takes one clock. A register write or saved-status write issued together with the change strobe lands in the bank being entered. Register 15 is stored like any other unbanked register.

Top module: `banked_regfile`

## Requirements
- R1: Both read ports are combinational and return the visible copy of the addressed register; a write with `wr_en` high updates the addressed register at the rising clock edge, and the new value is readable in the next cycle.
- R2: On a strobe, the bank is chosen from `mode[3:0]` alone: 0x1 fast-interrupt, 0x2 interrupt, 0x3 supervisor, 0x7 abort, 0xB undefined; 0x0, 0xF and every other code select the main bank.
- R3: Registers 13 and 14 have a separate copy in each of the six banks; after a bank change, reads of 13 and 14 return the copies last written in the entered bank.
- R4: Registers 8 to 12 return the fast-interrupt copy while the fast-interrupt bank is current and the shared copy otherwise; a change between two banks other than fast-interrupt leaves them unchanged.
- R5: A strobe whose mode code maps to the current bank (for example 0x10 to 0x1F) changes no register and no saved-status word.
- R6: Each non-main bank owns one saved-status word; `sts_rd_data` returns the current bank's word and `sts_wr_en` writes only that word.
- R7: In the main bank, `sts_rd_data` reads zero and a saved-status write is discarded.
- R8: A bank change completes in one clock; a register write or saved-status write presented in the same cycle as the strobe lands in the entered bank.
- R9: Reset makes the supervisor bank current and clears every register copy and every saved-status word to zero.
- R10: Registers 0 to 7 and 15 have one copy each and are never affected by a bank change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 4 | Read port A register number |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register number |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| mode | input | 5 | Target operating mode, sampled on the strobe |
| mode_chg | input | 1 | Mode change strobe |
| sts_wr_en | input | 1 | Saved-status write enable |
| sts_wr_data | input | 32 | Saved-status write data |
| sts_rd_data | output | 32 | Current bank's saved-status word |

## Verification
A wrong bank index or a missed swap stays hidden until a banked register is read. It then shows as a stale or foreign value on registers 8 to 14 or on the saved-status port, in the first cycle after the faulty change. A swap that runs when it should not, or a write that lands on the wrong side of the swap, is only exposed after a later change brings the damaged copy back into view. The bench therefore reads every register class after long random sequences of mode changes. It compares the reads against a model that keeps every copy in its own slot instead of swapping.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = 3;

    typedef enum logic [BANK_W-1:0] {
        BK_MAIN = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;
endpackage

// File: rtl/rf_bank_decode.sv
module rf_bank_decode #(
    parameter int MODE_W = 5
) (
    input  logic [MODE_W-1:0] mode,
    output rf_pkg::bank_e     bank
);
    import rf_pkg::*;

    logic unused_mode_hi;
    assign unused_mode_hi = ^mode[MODE_W-1:4];

    always_comb begin
        unique case (mode[3:0])
            4'h1:    bank = BK_FIQ;
            4'h2:    bank = BK_IRQ;
            4'h3:    bank = BK_SVC;
            4'h7:    bank = BK_ABT;
            4'hB:    bank = BK_UND;
            default: bank = BK_MAIN;
        endcase
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [AW-1:0]                   addr,
    output logic [DATA_W-1:0]               data
);
    assign data = regs[addr];
endmodule

// File: rtl/rf_status_bank.sv
module rf_status_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  rf_pkg::bank_e     wr_bank,
    input  rf_pkg::bank_e     rd_bank,
    output logic [DATA_W-1:0] rd_data
);
    import rf_pkg::*;

    typedef struct packed {
        logic [NUM_BANKS-1:0][DATA_W-1:0] word;
    } sts_t;

    sts_t sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (wr_en && wr_bank != BK_MAIN) begin
            sts_d.word[wr_bank] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign rd_data = (rd_bank == BK_MAIN) ? '0 : sts_q.word[rd_bank];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int  DATA_W   = 32,
    parameter int  NUM_REGS = 16,
    parameter int  MODE_W   = 5,
    localparam int AW       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              mode_chg,
    input  logic              sts_wr_en,
    input  logic [DATA_W-1:0] sts_wr_data,
    output logic [DATA_W-1:0] sts_rd_data
);
    import rf_pkg::*;

    localparam int SP_IDX = NUM_REGS - 3;
    localparam int LR_IDX = NUM_REGS - 2;
    localparam int FQ_LO  = NUM_REGS - 8;
    localparam int FQ_CNT = 5;
    localparam int NRP    = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0]     vis;
        logic [NUM_BANKS-1:0][1:0][DATA_W-1:0] stash;
        logic [FQ_CNT-1:0][DATA_W-1:0]        alt;
        bank_e                                bank;
    } core_t;

    core_t st_d, st_q;
    bank_e tgt_bank;
    bank_e bank_q;
    bank_e bank_d;

    rf_bank_decode #(.MODE_W(MODE_W)) u_dec (
        .mode (mode),
        .bank (tgt_bank)
    );

    always_comb begin
        st_d = st_q;
        if (mode_chg && tgt_bank != st_q.bank) begin
            st_d.stash[st_q.bank][0] = st_q.vis[SP_IDX];
            st_d.stash[st_q.bank][1] = st_q.vis[LR_IDX];
            st_d.vis[SP_IDX]         = st_q.stash[tgt_bank][0];
            st_d.vis[LR_IDX]         = st_q.stash[tgt_bank][1];
            if ((st_q.bank == BK_FIQ) != (tgt_bank == BK_FIQ)) begin
                for (int i = 0; i < FQ_CNT; i++) begin
                    st_d.alt[i]         = st_q.vis[FQ_LO + i];
                    st_d.vis[FQ_LO + i] = st_q.alt[i];
                end
            end
            st_d.bank = tgt_bank;
        end
        if (wr_en) begin
            st_d.vis[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bank <= BK_SVC;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q = st_q.bank;
    assign bank_d = st_d.bank;

    logic [NRP-1:0][AW-1:0]     rp_addr;
    logic [NRP-1:0][DATA_W-1:0] rp_data;
    assign rp_addr[0] = rd_addr_a;
    assign rp_addr[1] = rd_addr_b;

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rp (
            .regs (st_q.vis),
            .addr (rp_addr[p]),
            .data (rp_data[p])
        );
    end

    assign rd_data_a = rp_data[0];
    assign rd_data_b = rp_data[1];

    rf_status_bank #(.DATA_W(DATA_W)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sts_wr_en),
        .wr_data (sts_wr_data),
        .wr_bank (bank_d),
        .rd_bank (bank_q),
        .rd_data (sts_rd_data)
    );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 32,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [AW-1:0]     rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic              mode_chg,
    input rf_pkg::bank_e     tgt_bank,
    input rf_pkg::bank_e     cur_bank,
    input logic              sts_wr_en,
    input logic [DATA_W-1:0] sts_wr_data,
    input logic [DATA_W-1:0] sts_rd_data
);
    import rf_pkg::*;

    logic seen;
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(wr_en) && rd_addr_a == $past(wr_addr)) |-> rd_data_a == $past(wr_data));

    p_bank_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_bank) < NUM_BANKS);

    p_same_bank_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(mode_chg && tgt_bank == cur_bank && !wr_en && !sts_wr_en)
         && rd_addr_a == $past(rd_addr_a)) |-> (rd_data_a == $past(rd_data_a) && $stable(sts_rd_data)));

    p_status_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(sts_wr_en) && cur_bank != BK_MAIN) |-> sts_rd_data == $past(sts_wr_data));

    p_main_status_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bank == BK_MAIN |-> sts_rd_data == '0);

    p_low_unbanked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(wr_en) && rd_addr_a < AW'(8) && rd_addr_a == $past(rd_addr_a))
        |-> rd_data_a == $past(rd_data_a));
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr_a   (rd_addr_a),
    .rd_data_a   (rd_data_a),
    .mode_chg    (mode_chg),
    .tgt_bank    (tgt_bank),
    .cur_bank    (bank_q),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .sts_rd_data (sts_rd_data)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/1ps
module tb_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0, sts_wr_data = '0, sts_rd_data;
    logic        wr_en = 1'b0, mode_chg = 1'b0, sts_wr_en = 1'b0;
    logic [4:0]  mode = 5'h13;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode), .mode_chg(mode_chg),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data)
    );

    // Model: every copy kept in its own slot, no swapping.
    logic [31:0] m_sh  [16];
    logic [31:0] m_fq  [2][5];
    logic [31:0] m_bk  [6][2];
    logic [31:0] m_sts [6];
    int          m_cur;

    function automatic int bank_of(logic [4:0] md);
        case (md[3:0])
            4'h1: return 1;
            4'h2: return 2;
            4'h3: return 3;
            4'h7: return 4;
            4'hB: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_rd(logic [3:0] a);
        if (a >= 8 && a <= 12) return m_fq[(m_cur == 1) ? 1 : 0][a - 8];
        if (a == 13 || a == 14) return m_bk[m_cur][a - 13];
        return m_sh[a];
    endfunction

    function automatic string tag_of(logic [3:0] a);
        if (a >= 8 && a <= 12) return "R4";
        if (a == 13 || a == 14) return "R3";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_sh[i] = '0;
        for (int i = 0; i < 5; i++) begin m_fq[0][i] = '0; m_fq[1][i] = '0; end
        for (int b = 0; b < 6; b++) begin m_bk[b][0] = '0; m_bk[b][1] = '0; m_sts[b] = '0; end
        m_cur = 3;
    endtask

    // Called just after a falling edge: applies one cycle of stimulus.
    task automatic step(bit we, logic [3:0] wa, logic [31:0] wd, bit mc, logic [4:0] md,
                        bit swe, logic [31:0] swd);
        wr_en = we; wr_addr = wa; wr_data = wd;
        mode_chg = mc; mode = md;
        sts_wr_en = swe; sts_wr_data = swd;
        @(posedge clk);
        if (mc) m_cur = bank_of(md);
        if (we) begin
            if (wa >= 8 && wa <= 12) m_fq[(m_cur == 1) ? 1 : 0][wa - 8] = wd;
            else if (wa == 13 || wa == 14) m_bk[m_cur][wa - 13] = wd;
            else m_sh[wa] = wd;
        end
        if (swe && m_cur != 0) m_sts[m_cur] = swd;
        @(negedge clk);
        wr_en = 1'b0; mode_chg = 1'b0; sts_wr_en = 1'b0;
    endtask

    task automatic idle_mode(logic [4:0] md);
        step(1'b0, 4'h0, 32'h0, 1'b1, md, 1'b0, 32'h0);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        step(1'b1, a, d, 1'b0, 5'h0, 1'b0, 32'h0);
    endtask

    task automatic look(logic [3:0] a, logic [3:0] b);
        rd_addr_a = a; rd_addr_b = b;
        #1;
        chk(tag_of(a), rd_data_a, m_rd(a));
        chk(tag_of(b), rd_data_b, m_rd(b));
        chk((m_cur == 0) ? "R7" : "R6", sts_rd_data, (m_cur == 0) ? 32'h0 : m_sts[m_cur]);
    endtask

    task automatic peek(logic [3:0] a);
        rd_addr_a = a; #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [4:0] modes [7];
        void'($urandom(32'd20240611));
        modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset clears all copies; supervisor bank current
        for (int a = 0; a < 16; a++) begin peek(4'(a)); chk("R9", rd_data_a, 32'h0); end
        chk("R9", sts_rd_data, 32'h0);
        step(1'b0, 4'h0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h5A5A_0001);
        chk("R9", sts_rd_data, 32'h5A5A_0001);   // writable => not main bank

        // R1: write every register in supervisor bank
        for (int a = 0; a < 16; a++) wr(4'(a), 32'h1000_0000 + 32'(a));
        for (int a = 0; a < 16; a++) begin peek(4'(a)); chk("R1", rd_data_a, 32'h1000_0000 + 32'(a)); end

        // R8: enter fast-interrupt bank with same-cycle write to r9 and status
        step(1'b1, 4'd9, 32'hF1F1_0009, 1'b1, 5'h11, 1'b1, 32'hF1F1_5555);
        peek(4'd9);  chk("R8", rd_data_a, 32'hF1F1_0009);
        chk("R8", sts_rd_data, 32'hF1F1_5555);
        peek(4'd13); chk("R3", rd_data_a, 32'h0);
        peek(4'd10); chk("R4", rd_data_a, 32'h0);
        peek(4'd0);  chk("R10", rd_data_a, 32'h1000_0000);
        peek(4'd15); chk("R10", rd_data_a, 32'h1000_000F);

        // R7: user mode, status reads zero and discards writes
        idle_mode(5'h10);
        peek(4'd9);  chk("R4", rd_data_a, 32'h1000_0009);
        peek(4'd13); chk("R3", rd_data_a, 32'h0);
        chk("R7", sts_rd_data, 32'h0);
        step(1'b0, 4'h0, 32'h0, 1'b0, 5'h0, 1'b1, 32'hDEAD_BEEF);
        chk("R7", sts_rd_data, 32'h0);

        // R5: user to system keeps everything
        wr(4'd13, 32'h0000_0D13);
        idle_mode(5'h1F);
        peek(4'd13); chk("R5", rd_data_a, 32'h0000_0D13);
        chk("R5", sts_rd_data, 32'h0);

        // R3 / R6: back to supervisor restores its copies
        idle_mode(5'h13);
        peek(4'd13); chk("R3", rd_data_a, 32'h1000_000D);
        peek(4'd14); chk("R3", rd_data_a, 32'h1000_000E);
        chk("R6", sts_rd_data, 32'h5A5A_0001);
        idle_mode(5'h12);
        chk("R6", sts_rd_data, 32'h0);

        // R4: interrupt to abort leaves r8..r12 shared copy in place
        idle_mode(5'h17);
        peek(4'd12); chk("R4", rd_data_a, 32'h1000_000C);

        // R2: codes outside the table fall back to main bank
        idle_mode(5'h05);
        peek(4'd13); chk("R2", rd_data_a, 32'h0000_0D13);
        chk("R2", sts_rd_data, 32'h0);
        idle_mode(5'h0B);
        chk("R2", sts_rd_data, 32'h0);
        step(1'b0, 4'h0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h0B0B_0B0B);
        chk("R2", sts_rd_data, 32'h0B0B_0B0B);

        // Random phase against the slot model
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] md;
            md = ($urandom % 8 == 0) ? 5'($urandom) : modes[$urandom % 7];
            step(($urandom % 2) == 1, 4'($urandom), $urandom,
                 ($urandom % 3) == 0, md, ($urandom % 4) == 0, $urandom);
            look(4'($urandom), 4'(8 + ($urandom % 7)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule